// File: doc/BRIEF.md
# Bus Parity Generator and Error Reporter

This block handles even parity for a 32-bit multiplexed address/data bus and its four command/byte-enable lines. When the local agent owns the bus, the block produces the parity bit. That bit appears one clock after the address or data word it protects, so the bus gets one full cycle to settle before parity is needed. When the agent is receiving, the block captures the bus word and works out the parity it expects. On the next clock it compares that expected value with the parity bit arriving from the bus.

A mismatch in a completed data phase is reported on the shared data-error line. The line is pulled low for one cycle, two clocks after the faulty phase. It is then driven high for exactly one cycle and then released. A mismatch in an address phase is reported on the system-error line, which this block only ever pulls low or releases. A data mismatch during a special cycle is also reported there. Two enable inputs gate these two reports. Two sticky flags record what was detected, whatever the enables are, until a clear input is pulsed.

The block has plain control pins only, with no handshake. The transaction sequencer that decides who drives, and which cycles are address or data phases, sits outside this block. That sequencer feeds the phase qualifiers to this block.

Top module: `busparity_unit`

## Requirements
- R1: When `drive_en` is high in a cycle, the next cycle has `par_oe` high and `par_out` chosen so that the number of ones across `ad`, `cbe_n` and `par_out` together is even. When `drive_en` is low, the next cycle has `par_oe` low.
- R2: When receiving, the block compares `par_in` in the cycle after a phase against the parity of the `ad`/`cbe_n` values of that phase. If the two agree, no error is reported.
- R3: A data phase is checked only when `irdy_n` and `trdy_n` are both low, `addr_phase` is low and `drive_en` is low. An address phase (`addr_phase` high) is checked whenever `drive_en` is low.
- R4: A checked data phase with bad parity makes `perr_oe` high and `perr_out` low in the cycle two clocks after that phase. The low lasts one cycle per bad phase, so back-to-back bad phases give a longer low.
- R5: After the last low cycle, the data-error line is driven high (`perr_oe` high, `perr_out` high) for exactly one cycle. In the following cycle `perr_oe` is low.
- R6: When `perr_resp_en` is low, the data-error line is never driven.
- R7: The command latched in the last address phase may be 4'b0001, the special cycle. A bad data phase in such a transaction does not drive the data-error line. Instead it raises `serr_pull` two clocks after the phase.
- R8: An address phase with bad parity raises `serr_pull` for one cycle, two clocks after the phase, but only if `serr_en` is high. `serr_pull` only means "pull the line low"; the block has no output that drives the system-error line high.
- R9: `dpe_flag` is set by any data parity error. `ape_flag` is set by any address parity error. Both are set whatever the enables are, becoming visible two clocks after the phase. Each holds until its clear input is high at a clock edge. A set in the same edge as a clear wins.
- R10: After reset, `par_oe`, `perr_oe`, `serr_pull`, `dpe_flag` and `ape_flag` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_en | input | 1 | Local agent drives `ad`/`cbe_n` this cycle |
| addr_phase | input | 1 | This cycle is an address phase |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| ad | input | 32 | Address/data bus value |
| cbe_n | input | 4 | Command (address phase) or byte enables (data phase), as on the wire |
| par_in | input | 1 | Parity bit seen on the bus |
| perr_resp_en | input | 1 | Allows the data-error line to be driven |
| serr_en | input | 1 | Allows the system-error line to be pulled |
| dpe_clr | input | 1 | Clears `dpe_flag` |
| ape_clr | input | 1 | Clears `ape_flag` |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Output enable for `par_out` |
| perr_out | output | 1 | Data-error line level when driven |
| perr_oe | output | 1 | Output enable for the data-error line |
| serr_pull | output | 1 | Pull system-error line low |
| dpe_flag | output | 1 | Sticky data parity error |
| ape_flag | output | 1 | Sticky address parity error |

## Verification
The bench aims at the timing of the error line. A design that reports one cycle early or late, that skips the single high cycle before release, or that drives high twice between back-to-back bad phases would show the wrong level at the checked cycle. It sends bad parity in wait-state cycles and in cycles the agent drives itself; a design that ignored the qualifiers would pulse the error line there. It also runs a special-cycle transaction with bad data. A design that did not latch the address-phase command would pulse the data-error line instead of the system-error line. Further checks cover disabled reporting paired with a still-set sticky flag, and the clear of both flags.

// File: rtl/busparity_pkg.sv
package busparity_pkg;
  parameter logic [3:0] SPECIAL_CMD = 4'b0001;

  typedef struct packed {
    logic data_bad;
    logic data_special;
    logic addr_bad;
  } chk_err_t;
endpackage

// File: rtl/bp_parity_tree.sv
module bp_parity_tree #(
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input  logic [DATA_W-1:0] ad,
  input  logic [BE_W-1:0]   cbe_n,
  output logic              par
);
  localparam int LANE_W = DATA_W / BE_W;

  logic [BE_W-1:0] lane_par;

  // each byte lane folded together with its own enable line
  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign lane_par[g] = ^{ad[g*LANE_W +: LANE_W], cbe_n[g]};
  end

  assign par = ^lane_par;
endmodule

// File: rtl/bp_gen.sv
module bp_gen #(
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive_en,
  input  logic [DATA_W-1:0] ad,
  input  logic [BE_W-1:0]   cbe_n,
  output logic              par_out,
  output logic              par_oe
);
  logic calc;

  bp_parity_tree #(.DATA_W(DATA_W), .BE_W(BE_W)) u_tree (
    .ad(ad), .cbe_n(cbe_n), .par(calc)
  );

  // parity lags its word by one clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_out <= 1'b0;
      par_oe  <= 1'b0;
    end else begin
      par_out <= calc;
      par_oe  <= drive_en;
    end
  end
endmodule

// File: rtl/bp_check.sv
module bp_check
  import busparity_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive_en,
  input  logic              addr_phase,
  input  logic              irdy_n,
  input  logic              trdy_n,
  input  logic [DATA_W-1:0] ad,
  input  logic [BE_W-1:0]   cbe_n,
  input  logic              par_in,
  output chk_err_t          err
);
  localparam logic [BE_W-1:0] SPECIAL = BE_W'(SPECIAL_CMD);

  logic            calc;
  logic            exp_q;
  logic            dchk_q;
  logic            achk_q;
  logic            spec_q;
  logic [BE_W-1:0] cmd_q;
  logic            mismatch;

  bp_parity_tree #(.DATA_W(DATA_W), .BE_W(BE_W)) u_tree (
    .ad(ad), .cbe_n(cbe_n), .par(calc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q  <= 1'b0;
      dchk_q <= 1'b0;
      achk_q <= 1'b0;
      spec_q <= 1'b0;
      cmd_q  <= '0;
    end else begin
      exp_q  <= calc;
      achk_q <= addr_phase && !drive_en;
      dchk_q <= !addr_phase && !drive_en && !irdy_n && !trdy_n;
      spec_q <= (cmd_q == SPECIAL);
      if (addr_phase) cmd_q <= cbe_n;
    end
  end

  // parity bit arrives one clock after the word captured in exp_q
  assign mismatch         = exp_q ^ par_in;
  assign err.data_bad     = dchk_q && mismatch && !spec_q;
  assign err.data_special = dchk_q && mismatch && spec_q;
  assign err.addr_bad     = achk_q && mismatch;
endmodule

// File: rtl/bp_report.sv
module bp_report
  import busparity_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  chk_err_t err,
  input  logic     perr_resp_en,
  input  logic     serr_en,
  input  logic     dpe_clr,
  input  logic     ape_clr,
  output logic     perr_out,
  output logic     perr_oe,
  output logic     serr_pull,
  output logic     dpe_flag,
  output logic     ape_flag
);
  logic perr_low_q;
  logic perr_rel_q;
  logic perr_req;

  assign perr_req = perr_resp_en && err.data_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_low_q <= 1'b0;
      perr_rel_q <= 1'b0;
      serr_pull  <= 1'b0;
      dpe_flag   <= 1'b0;
      ape_flag   <= 1'b0;
    end else begin
      perr_low_q <= perr_req;
      perr_rel_q <= perr_low_q && !perr_req;
      serr_pull  <= serr_en && (err.addr_bad || err.data_special);
      dpe_flag   <= err.data_bad || err.data_special || (dpe_flag && !dpe_clr);
      ape_flag   <= err.addr_bad || (ape_flag && !ape_clr);
    end
  end

  assign perr_oe  = perr_low_q || perr_rel_q;
  assign perr_out = !perr_low_q;
endmodule

// File: rtl/busparity_unit.sv
module busparity_unit
  import busparity_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive_en,
  input  logic              addr_phase,
  input  logic              irdy_n,
  input  logic              trdy_n,
  input  logic [DATA_W-1:0] ad,
  input  logic [BE_W-1:0]   cbe_n,
  input  logic              par_in,
  input  logic              perr_resp_en,
  input  logic              serr_en,
  input  logic              dpe_clr,
  input  logic              ape_clr,
  output logic              par_out,
  output logic              par_oe,
  output logic              perr_out,
  output logic              perr_oe,
  output logic              serr_pull,
  output logic              dpe_flag,
  output logic              ape_flag
);
  chk_err_t err;

  bp_gen #(.DATA_W(DATA_W), .BE_W(BE_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .drive_en(drive_en), .ad(ad), .cbe_n(cbe_n),
    .par_out(par_out), .par_oe(par_oe)
  );

  bp_check #(.DATA_W(DATA_W), .BE_W(BE_W)) u_check (
    .clk(clk), .rst_n(rst_n), .drive_en(drive_en), .addr_phase(addr_phase),
    .irdy_n(irdy_n), .trdy_n(trdy_n), .ad(ad), .cbe_n(cbe_n),
    .par_in(par_in), .err(err)
  );

  bp_report u_report (
    .clk(clk), .rst_n(rst_n), .err(err), .perr_resp_en(perr_resp_en),
    .serr_en(serr_en), .dpe_clr(dpe_clr), .ape_clr(ape_clr),
    .perr_out(perr_out), .perr_oe(perr_oe), .serr_pull(serr_pull),
    .dpe_flag(dpe_flag), .ape_flag(ape_flag)
  );
endmodule

// File: rtl/busparity_unit_chk.sv
module busparity_unit_chk #(
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              drive_en,
  input logic              addr_phase,
  input logic              irdy_n,
  input logic              trdy_n,
  input logic [DATA_W-1:0] ad,
  input logic [BE_W-1:0]   cbe_n,
  input logic              perr_resp_en,
  input logic              serr_en,
  input logic              dpe_clr,
  input logic              par_out,
  input logic              par_oe,
  input logic              perr_out,
  input logic              perr_oe,
  input logic              serr_pull,
  input logic              dpe_flag
);
  p_par_lag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(drive_en) |-> par_oe && ((^{$past(ad), $past(cbe_n), par_out}) == 1'b0));

  p_par_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(drive_en) |-> !par_oe);

  p_perr_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && !perr_out) |-> $past(!drive_en && !addr_phase && !irdy_n && !trdy_n, 2));

  p_perr_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(perr_oe && !perr_out) && !(perr_oe && !perr_out) |-> perr_oe && perr_out);

  p_perr_high_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(perr_oe && perr_out) |-> !(perr_oe && perr_out));

  p_perr_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && !perr_out) |-> $past(perr_resp_en));

  p_serr_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    serr_pull |-> $past(serr_en));

  p_dpe_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(dpe_flag) && !$past(dpe_clr) |-> dpe_flag);
endmodule

bind busparity_unit busparity_unit_chk #(.DATA_W(DATA_W), .BE_W(BE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .drive_en(drive_en), .addr_phase(addr_phase),
  .irdy_n(irdy_n), .trdy_n(trdy_n), .ad(ad), .cbe_n(cbe_n),
  .perr_resp_en(perr_resp_en), .serr_en(serr_en), .dpe_clr(dpe_clr),
  .par_out(par_out), .par_oe(par_oe), .perr_out(perr_out), .perr_oe(perr_oe),
  .serr_pull(serr_pull), .dpe_flag(dpe_flag)
);

// File: tb/busparity_unit_test.sv
`timescale 1ns/1ps
module busparity_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        drive_en = 1'b0, addr_phase = 1'b0, irdy_n = 1'b1, trdy_n = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic        par_in = 1'b0;
  logic        perr_resp_en = 1'b1, serr_en = 1'b1, dpe_clr = 1'b0, ape_clr = 1'b0;
  logic        par_out, par_oe, perr_out, perr_oe, serr_pull, dpe_flag, ape_flag;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  busparity_unit uut (
    .clk(clk), .rst_n(rst_n), .drive_en(drive_en), .addr_phase(addr_phase),
    .irdy_n(irdy_n), .trdy_n(trdy_n), .ad(ad), .cbe_n(cbe_n), .par_in(par_in),
    .perr_resp_en(perr_resp_en), .serr_en(serr_en), .dpe_clr(dpe_clr),
    .ape_clr(ape_clr), .par_out(par_out), .par_oe(par_oe), .perr_out(perr_out),
    .perr_oe(perr_oe), .serr_pull(serr_pull), .dpe_flag(dpe_flag), .ape_flag(ape_flag)
  );

  function automatic logic even_bit(input logic [31:0] a, input logic [3:0] c);
    return ($countones({a, c}) % 2) == 1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    drive_en = 1'b0; addr_phase = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1;
  endtask

  task automatic clear_flags();
    @(negedge clk); dpe_clr = 1'b1; ape_clr = 1'b1;
    @(negedge clk); dpe_clr = 1'b0; ape_clr = 1'b0;
  endtask

  // drives one phase, then its parity bit; returns one cycle after the phase
  task automatic rx(input logic is_addr, input logic [31:0] a, input logic [3:0] c,
                    input logic bad, input logic ir, input logic tr, input logic drv);
    @(negedge clk);
    ad = a; cbe_n = c; addr_phase = is_addr; irdy_n = ir; trdy_n = tr; drive_en = drv;
    @(negedge clk);
    idle();
    par_in = even_bit(a, c) ^ bad;
    ad = ~a;
  endtask

  task automatic t_reset();
    chk("R10 par_oe", par_oe, 0);
    chk("R10 perr_oe", perr_oe, 0);
    chk("R10 serr_pull", serr_pull, 0);
    chk("R10 dpe_flag", dpe_flag, 0);
    chk("R10 ape_flag", ape_flag, 0);
  endtask

  task automatic gen_one(input logic [31:0] a, input logic [3:0] c);
    @(negedge clk); drive_en = 1'b1; ad = a; cbe_n = c;
    @(negedge clk); drive_en = 1'b0;
    chk("R1 par_oe on", par_oe, 1);
    chk("R1 par_out", par_out, even_bit(a, c));
    @(negedge clk);
    chk("R1 par_oe off", par_oe, 0);
  endtask

  task automatic t_gen();
    gen_one(32'h0000_0000, 4'h0);
    gen_one(32'hFFFF_FFFF, 4'hE);
    gen_one(32'h1234_5678, 4'h3);
    gen_one(32'h8000_0001, 4'h1);
  endtask

  task automatic t_good_data();
    rx(1'b0, 32'hCAFE_0001, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R2 good parity no perr", perr_oe, 0);
    chk("R2 good parity no flag", dpe_flag, 0);
  endtask

  task automatic t_bad_data();
    rx(1'b0, 32'hDEAD_BEEF, 4'h5, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R4 perr_oe low phase", perr_oe, 1);
    chk("R4 perr_out low", perr_out, 0);
    chk("R9 dpe_flag set", dpe_flag, 1);
    chk("R7 no serr for normal data", serr_pull, 0);
    @(negedge clk);
    chk("R5 perr_oe high phase", perr_oe, 1);
    chk("R5 perr_out high", perr_out, 1);
    @(negedge clk);
    chk("R5 released", perr_oe, 0);
    chk("R9 dpe_flag held", dpe_flag, 1);
    clear_flags();
    chk("R9 dpe_flag cleared", dpe_flag, 0);
  endtask

  task automatic t_unqualified();
    rx(1'b0, 32'h0F0F_0F0F, 4'h0, 1'b1, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chk("R3 wait state ignored", perr_oe, 0);
    rx(1'b0, 32'h0F0F_0F0F, 4'h0, 1'b1, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R3 own drive ignored", perr_oe, 0);
    chk("R3 own drive no flag", dpe_flag, 0);
  endtask

  task automatic t_perr_disabled();
    perr_resp_en = 1'b0;
    rx(1'b0, 32'h5555_AAAA, 4'h9, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R6 perr not driven", perr_oe, 0);
    chk("R9 flag despite disable", dpe_flag, 1);
    @(negedge clk);
    chk("R6 perr not driven later", perr_oe, 0);
    perr_resp_en = 1'b1;
    clear_flags();
  endtask

  task automatic t_back2back();
    @(negedge clk);
    ad = 32'h1111_0000; cbe_n = 4'h0; irdy_n = 1'b0; trdy_n = 1'b0;
    @(negedge clk);
    par_in = ~even_bit(32'h1111_0000, 4'h0);
    ad = 32'h2222_0000; cbe_n = 4'h3;
    @(negedge clk);
    idle();
    par_in = ~even_bit(32'h2222_0000, 4'h3);
    chk("R4 first low", {perr_oe, perr_out}, 2'b10);
    @(negedge clk);
    chk("R4 second low", {perr_oe, perr_out}, 2'b10);
    @(negedge clk);
    chk("R5 one high after run", {perr_oe, perr_out}, 2'b11);
    @(negedge clk);
    chk("R5 released after run", perr_oe, 0);
    clear_flags();
  endtask

  task automatic t_addr_err();
    rx(1'b1, 32'h8000_1000, 4'h6, 1'b1, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    chk("R8 serr on address error", serr_pull, 1);
    chk("R8 no perr on address error", perr_oe, 0);
    chk("R9 ape_flag set", ape_flag, 1);
    @(negedge clk);
    chk("R8 serr single cycle", serr_pull, 0);
    clear_flags();
    chk("R9 ape_flag cleared", ape_flag, 0);
    serr_en = 1'b0;
    rx(1'b1, 32'h8000_2000, 4'h7, 1'b1, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    chk("R8 serr gated", serr_pull, 0);
    chk("R9 ape_flag despite gate", ape_flag, 1);
    serr_en = 1'b1;
    clear_flags();
  endtask

  task automatic t_special();
    rx(1'b1, 32'h0000_0000, 4'h1, 1'b0, 1'b1, 1'b1, 1'b0);
    rx(1'b0, 32'h0000_ABCD, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R7 special no perr", perr_oe, 0);
    chk("R7 special goes to serr", serr_pull, 1);
    chk("R7 special sets dpe_flag", dpe_flag, 1);
    rx(1'b1, 32'h0000_0040, 4'h6, 1'b0, 1'b1, 1'b1, 1'b0);
    clear_flags();
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gen();
    t_good_data();
    t_bad_data();
    t_unqualified();
    t_perr_disabled();
    t_back2back();
    t_addr_err();
    t_special();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule